// File: doc/BRIEF.md
# Readout Window Frame and Row Sequencer

This block sets the timing for reading a global-shutter pixel array whose pixels leave through several parallel channels. A register-write port loads a staging copy of the settings: the frame overhead length, the row overhead length, the window origin and extent in both axes, and a line-skipping enable. A frame trigger copies the staged settings into the active set. The block then counts out the frame overhead. For each selected line it counts out the row overhead and then steps through the column groups of the window, one group per channel clock.

Downstream logic uses `frame_valid`, `line_valid`, the row address and the column-group address to steer the channel data. A single-cycle `frame_done` marks the end of a frame. These outputs are plain control signals with no back-pressure: the pixel array cannot be stalled, so the sequencer never waits on a consumer. Column settings that do not fall on the column alignment step are trimmed down to it and reported through a sticky flag. Windows that reach past the array are cut to fit.

Top module: `readout_window_seq`

## Requirements
- R1: After reset, `frame_valid`, `line_valid`, `frame_done` and `align_err` are 0, and both addresses are 0. The staged settings are: frame overhead `FOT_RESET` (315), row overhead `ROT_RESET` (13), a full-array window, and line skipping off.
- R2: Writes take effect on a clock edge when `cfg_we` is 1. The register addresses are: 0 frame overhead, 1 row overhead, 2 column start, 3 column width, 4 first row, 5 row count, 6 line skipping (bit 0). Other addresses are ignored. After the trigger edge, `frame_valid` stays low for max(F,1) cycles, where F is the frame overhead.
- R3: Each line is preceded by max(R,1) cycles with `frame_valid` 1 and `line_valid` 0, where R is the row overhead. `line_valid` is never 1 while `frame_valid` is 0.
- R4: During a line, `line_valid` is 1 for W/CHANNELS consecutive cycles, where W is the effective column width. `col_grp` starts at start/CHANNELS and rises by one each cycle.
- R5: Lines start at the first row and advance by 1, or by 2 when line skipping is on. They continue while the row is below first row plus row count. `row_addr` holds the current line through its overhead and pixel cycles.
- R6: A value written to column start or column width is rounded down to a multiple of `COL_STEP` (24). A nonzero remainder sets `align_err`, which stays 1 until reset.
- R7: The active settings change only at an accepted trigger. A write made during a frame, or in the same cycle as the trigger, applies from the next frame. A trigger is ignored while a frame is running.
- R8: Clipping works as follows:
  - A column start beyond `COLS-COL_STEP` becomes `COLS-COL_STEP`.
  - A first row beyond `ROWS-1` becomes `ROWS-1`.
  - Width and row count are cut to what remains of the array.
  - A zero width reads as `COL_STEP` and a zero row count reads as 1.
- R9: `frame_done` is 1 for exactly one cycle, the cycle after the last column group of the last line. In that cycle `frame_valid` is 0.
- R10: The cycles from the trigger edge to `frame_done` number max(F,1) + L*(max(R,1) + W/CHANNELS), where L is the number of lines read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write value |
| frame_trig | input | 1 | Frame start request |
| frame_valid | output | 1 | High during row overhead and pixel cycles |
| line_valid | output | 1 | High during pixel cycles of a line |
| row_addr | output | clog2(ROWS) | Current line |
| col_grp | output | clog2(COLS/CHANNELS) | Current column group |
| frame_done | output | 1 | Single-cycle end-of-frame pulse |
| align_err | output | 1 | Sticky misaligned column write flag |

## Verification
A register write and a frame trigger can land on the same clock edge. The write enters the staging copy, while the trigger copies the staging copy as it stood before that edge. The bench drives both in one cycle and judges by frame overhead length: the old value must be measured on the first frame and the new value on the next. A trigger sent during a running frame is also provoked, together with writes in the middle of the frame. The bench checks that the current frame's row overhead is unchanged and that no second frame follows.

// File: rtl/rws_pkg.sv
package rws_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FOT  = 2'd1,
    ST_ROT  = 2'd2,
    ST_PIX  = 2'd3
  } seq_state_t;

  localparam logic [2:0] REG_FOT    = 3'd0;
  localparam logic [2:0] REG_ROT    = 3'd1;
  localparam logic [2:0] REG_XSTART = 3'd2;
  localparam logic [2:0] REG_XSIZE  = 3'd3;
  localparam logic [2:0] REG_YSTART = 3'd4;
  localparam logic [2:0] REG_YSIZE  = 3'd5;
  localparam logic [2:0] REG_SUB    = 3'd6;

  // Fit a requested span into what remains of the array; zero means minimum.
  function automatic int clip_span(int req, int avail, int floor_v);
    if (req == 0)     return floor_v;
    if (req > avail)  return avail;
    return req;
  endfunction

endpackage

// File: rtl/rws_cfg_regs.sv
module rws_cfg_regs
  import rws_pkg::*;
#(
  parameter int COLS      = 1296,
  parameter int ROWS      = 1025,
  parameter int CH        = 12,
  parameter int COL_STEP  = 24,
  parameter int FOT_RESET = 315,
  parameter int ROT_RESET = 13,
  parameter int DW        = 16,
  parameter int ROW_W     = 11,
  parameter int GRP_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             load,
  input  logic             busy,
  output logic [DW-1:0]    nxt_fot,
  output logic [ROW_W-1:0] nxt_first_row,
  output logic [DW-1:0]    act_rot,
  output logic [GRP_W-1:0] act_first_grp,
  output logic [GRP_W:0]   act_num_grp,
  output logic [ROW_W:0]   act_row_end,
  output logic             act_sub,
  output logic             align_err
);

  logic [DW-1:0] st_fot, st_rot, st_xs, st_xw, st_ys, st_yh;
  logic          st_sub;
  logic [DW-1:0] wr_rem;
  logic          col_wr;

  logic [GRP_W-1:0] nxt_first_grp;
  logic [GRP_W:0]   nxt_num_grp;
  logic [ROW_W:0]   nxt_row_end;

  assign wr_rem = cfg_wdata % DW'(COL_STEP);
  assign col_wr = cfg_we && (cfg_addr == REG_XSTART || cfg_addr == REG_XSIZE);

  // Staging copy: software-visible, written at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_fot <= DW'(FOT_RESET);
      st_rot <= DW'(ROT_RESET);
      st_xs  <= '0;
      st_xw  <= DW'(COLS);
      st_ys  <= '0;
      st_yh  <= DW'(ROWS);
      st_sub <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        REG_FOT:    st_fot <= cfg_wdata;
        REG_ROT:    st_rot <= cfg_wdata;
        REG_XSTART: st_xs  <= cfg_wdata - wr_rem;
        REG_XSIZE:  st_xw  <= cfg_wdata - wr_rem;
        REG_YSTART: st_ys  <= cfg_wdata;
        REG_YSIZE:  st_yh  <= cfg_wdata;
        REG_SUB:    st_sub <= cfg_wdata[0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          align_err <= 1'b0;
    else if (col_wr && (wr_rem != '0))   align_err <= 1'b1;
  end

  // Clipped view of the staging copy
  always_comb begin
    int xs, xw, ys, yh;
    xs = int'(st_xs);
    if (xs > COLS - COL_STEP) xs = COLS - COL_STEP;
    xw = clip_span(int'(st_xw), COLS - xs, COL_STEP);
    ys = int'(st_ys);
    if (ys > ROWS - 1) ys = ROWS - 1;
    yh = clip_span(int'(st_yh), ROWS - ys, 1);
    nxt_fot       = st_fot;
    nxt_first_row = ROW_W'(ys);
    nxt_first_grp = GRP_W'(xs / CH);
    nxt_num_grp   = (GRP_W+1)'(xw / CH);
    nxt_row_end   = (ROW_W+1)'(ys + yh);
  end

  // Active copy: frozen for the whole frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_rot       <= DW'(ROT_RESET);
      act_first_grp <= '0;
      act_num_grp   <= (GRP_W+1)'(COLS / CH);
      act_row_end   <= (ROW_W+1)'(ROWS);
      act_sub       <= 1'b0;
    end else if (load) begin
      act_rot       <= st_rot;
      act_first_grp <= nxt_first_grp;
      act_num_grp   <= nxt_num_grp;
      act_row_end   <= nxt_row_end;
      act_sub       <= st_sub;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(act_rot) && $stable(act_num_grp) && $stable(act_row_end) && $stable(act_sub))); // R7
  AST_ALIGN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> align_err); // R6
  AST_ACT_WIDTH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (act_num_grp != '0)); // R8

endmodule

// File: rtl/rws_timer.sv
module rws_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);

  logic [W-1:0] cnt;

  // A length of L gives max(L,1) cycles until expired
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= (len == '0) ? '0 : len - W'(1);
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/rws_addr_gen.sv
module rws_addr_gen #(
  parameter int ROWS  = 1025,
  parameter int GROUPS = 108,
  parameter int ROW_W = 11,
  parameter int GRP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_load,
  input  logic [ROW_W-1:0] first_row,
  input  logic             row_adv,
  input  logic             sub,
  input  logic [ROW_W:0]   row_end,
  input  logic             line_load,
  input  logic [GRP_W-1:0] first_grp,
  input  logic [GRP_W:0]   num_grp,
  input  logic             grp_adv,
  output logic [ROW_W-1:0] row_addr,
  output logic [GRP_W-1:0] col_grp,
  output logic             last_row,
  output logic             last_grp
);

  logic [ROW_W:0] step;
  logic [GRP_W:0] gcnt;

  assign step = sub ? (ROW_W+1)'(2) : (ROW_W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          row_addr <= '0;
    else if (frame_load) row_addr <= first_row;
    else if (row_adv)    row_addr <= row_addr + step[ROW_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_grp <= '0;
      gcnt    <= '0;
    end else if (line_load) begin
      col_grp <= first_grp;
      gcnt    <= '0;
    end else if (grp_adv) begin
      col_grp <= col_grp + GRP_W'(1);
      gcnt    <= gcnt + (GRP_W+1)'(1);
    end
  end

  assign last_row = ({1'b0, row_addr} + step) >= row_end;
  assign last_grp = (gcnt + (GRP_W+1)'(1)) == num_grp;

  AST_ROW_IN_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    int'(row_addr) < ROWS); // R8
  AST_COL_IN_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col_grp) < GROUPS); // R8
  AST_LOAD_ADV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_load && grp_adv)); // R4

endmodule

// File: rtl/readout_window_seq.sv
module readout_window_seq
  import rws_pkg::*;
#(
  parameter int ARRAY_COLS = 1296,
  parameter int ARRAY_ROWS = 1025,
  parameter int CHANNELS   = 12,
  parameter int COL_STEP   = 24,
  parameter int FOT_RESET  = 315,
  parameter int ROT_RESET  = 13,
  parameter int DW         = 16,
  localparam int GROUPS    = ARRAY_COLS / CHANNELS,
  localparam int ROW_W     = $clog2(ARRAY_ROWS),
  localparam int GRP_W     = $clog2(GROUPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             frame_trig,
  output logic             frame_valid,
  output logic             line_valid,
  output logic [ROW_W-1:0] row_addr,
  output logic [GRP_W-1:0] col_grp,
  output logic             frame_done,
  output logic             align_err
);

  seq_state_t st, nst;

  logic [DW-1:0]    nxt_fot, act_rot, tmr_len;
  logic [ROW_W-1:0] nxt_first_row;
  logic [GRP_W-1:0] act_first_grp;
  logic [GRP_W:0]   act_num_grp;
  logic [ROW_W:0]   act_row_end;
  logic             act_sub;
  logic             tmr_load, tmr_exp;
  logic             frame_load, row_adv, line_load, grp_adv;
  logic             last_row, last_grp, done_nxt, busy;

  assign busy = (st != ST_IDLE);

  rws_cfg_regs #(
    .COLS(ARRAY_COLS), .ROWS(ARRAY_ROWS), .CH(CHANNELS), .COL_STEP(COL_STEP),
    .FOT_RESET(FOT_RESET), .ROT_RESET(ROT_RESET), .DW(DW),
    .ROW_W(ROW_W), .GRP_W(GRP_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .load(frame_load), .busy(busy),
    .nxt_fot(nxt_fot), .nxt_first_row(nxt_first_row),
    .act_rot(act_rot), .act_first_grp(act_first_grp), .act_num_grp(act_num_grp),
    .act_row_end(act_row_end), .act_sub(act_sub),
    .align_err(align_err)
  );

  rws_timer #(.W(DW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .expired(tmr_exp)
  );

  rws_addr_gen #(
    .ROWS(ARRAY_ROWS), .GROUPS(GROUPS), .ROW_W(ROW_W), .GRP_W(GRP_W)
  ) u_addr (
    .clk(clk), .rst_n(rst_n),
    .frame_load(frame_load), .first_row(nxt_first_row),
    .row_adv(row_adv), .sub(act_sub), .row_end(act_row_end),
    .line_load(line_load), .first_grp(act_first_grp), .num_grp(act_num_grp),
    .grp_adv(grp_adv),
    .row_addr(row_addr), .col_grp(col_grp),
    .last_row(last_row), .last_grp(last_grp)
  );

  always_comb begin
    nst        = st;
    tmr_load   = 1'b0;
    tmr_len    = act_rot;
    frame_load = 1'b0;
    row_adv    = 1'b0;
    line_load  = 1'b0;
    grp_adv    = 1'b0;
    done_nxt   = 1'b0;
    case (st)
      ST_IDLE: if (frame_trig) begin
        nst        = ST_FOT;
        frame_load = 1'b1;
        tmr_load   = 1'b1;
        tmr_len    = nxt_fot;
      end
      ST_FOT: if (tmr_exp) begin
        nst      = ST_ROT;
        tmr_load = 1'b1;
      end
      ST_ROT: if (tmr_exp) begin
        nst       = ST_PIX;
        line_load = 1'b1;
      end
      ST_PIX: begin
        grp_adv = !last_grp;
        if (last_grp) begin
          if (last_row) begin
            nst      = ST_IDLE;
            done_nxt = 1'b1;
          end else begin
            nst      = ST_ROT;
            row_adv  = 1'b1;
            tmr_load = 1'b1;
          end
        end
      end
      default: nst = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      frame_done <= 1'b0;
    end else begin
      st         <= nst;
      frame_done <= done_nxt;
    end
  end

  assign frame_valid = (st == ST_ROT) || (st == ST_PIX);
  assign line_valid  = (st == ST_PIX);

  AST_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> frame_valid); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R9
  AST_DONE_AFTER_PIX: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($past(line_valid) && !frame_valid)); // R9
  AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame_trig) |=> (frame_valid || frame_done)); // R7
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && $past(line_valid)) |-> (col_grp == $past(col_grp) + GRP_W'(1))); // R4

endmodule

// File: tb/readout_window_seq_bench.sv
module readout_window_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BC = 240;
  localparam int BR = 40;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic frame_trig = 1'b0;
  logic frame_valid, line_valid, frame_done, align_err;
  logic [$clog2(BR)-1:0] row_addr;
  logic [$clog2(BC/12)-1:0] col_grp;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  readout_window_seq #(.ARRAY_COLS(BC), .ARRAY_ROWS(BR)) u_readout_window_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_trig(frame_trig),
    .frame_valid(frame_valid), .line_valid(line_valid), .row_addr(row_addr),
    .col_grp(col_grp), .frame_done(frame_done), .align_err(align_err)
  );

  typedef struct packed {
    logic [15:0] fot, rot, xs, xw, ys, yh, sub;
    logic [15:0] e_f, e_r, e_l, e_g, e_fr, e_lr, e_fg, e_al;
  } vec_t;

  // settings | expected: overhead F, R, lines, groups, first row, last row, first group, align
  localparam vec_t TBL [7] = '{
    '{16'd5, 16'd2, 16'd0,   16'd240, 16'd0,   16'd40, 16'd0, 16'd5, 16'd2, 16'd40, 16'd20, 16'd0,  16'd39, 16'd0,  16'd0}, // R5 full window
    '{16'd1, 16'd1, 16'd48,  16'd96,  16'd10,  16'd5,  16'd0, 16'd1, 16'd1, 16'd5,  16'd8,  16'd10, 16'd14, 16'd4,  16'd0}, // R4 inner window
    '{16'd3, 16'd4, 16'd24,  16'd48,  16'd3,   16'd7,  16'd1, 16'd3, 16'd4, 16'd4,  16'd4,  16'd3,  16'd9,  16'd2,  16'd0}, // R5 skip rows
    '{16'd0, 16'd0, 16'd216, 16'd72,  16'd38,  16'd10, 16'd0, 16'd1, 16'd1, 16'd2,  16'd2,  16'd38, 16'd39, 16'd18, 16'd0}, // R8 size clip, zero overheads
    '{16'd4, 16'd2, 16'd600, 16'd48,  16'd100, 16'd3,  16'd1, 16'd4, 16'd2, 16'd1,  16'd2,  16'd39, 16'd39, 16'd18, 16'd0}, // R8 start clip
    '{16'd2, 16'd3, 16'd50,  16'd30,  16'd0,   16'd6,  16'd1, 16'd2, 16'd3, 16'd3,  16'd2,  16'd0,  16'd4,  16'd4,  16'd1}, // R6 rounding
    '{16'd1, 16'd2, 16'd0,   16'd0,   16'd5,   16'd0,  16'd0, 16'd1, 16'd2, 16'd1,  16'd2,  16'd5,  16'd5,  16'd0,  16'd1}  // R8 zero sizes, R6 sticky
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_vec(input vec_t v);
    wr(3'd0, int'(v.fot)); wr(3'd1, int'(v.rot));
    wr(3'd2, int'(v.xs));  wr(3'd3, int'(v.xw));
    wr(3'd4, int'(v.ys));  wr(3'd5, int'(v.yh));
    wr(3'd6, int'(v.sub));
  endtask

  // Runs one frame and checks its shape at the ports.
  task automatic run_frame(input bit do_trig, input int ef, input int er, input int el,
                           input int eg, input int efr, input int elr, input int efg,
                           input int step);
    int mf, ml, rcnt, gcnt, rbad, gbad, sbad, fr, lr, fg, cyc;
    bit seen;
    mf = 0; ml = 0; rcnt = 0; gcnt = 0; rbad = 0; gbad = 0; sbad = 0;
    fr = -1; lr = -1; fg = -1; cyc = 0; seen = 0;
    if (do_trig) begin
      @(negedge clk); frame_trig = 1'b1;
    end
    @(negedge clk);
    frame_trig = 1'b0; cfg_we = 1'b0;
    while (frame_done !== 1'b1 && cyc < LIMIT) begin
      if (!frame_valid) begin
        if (!seen) mf++;
      end else begin
        seen = 1;
        if (!line_valid) begin
          if (gcnt != 0) begin
            if (gcnt != eg) gbad++;
            gcnt = 0;
          end
          rcnt++;
        end else begin
          if (gcnt == 0) begin
            ml++;
            if (rcnt != er) rbad++;
            rcnt = 0;
            if (ml == 1) begin
              fr = int'(row_addr); fg = int'(col_grp);
            end else if (int'(row_addr) - lr != step) sbad++;
            lr = int'(row_addr);
          end
          gcnt++;
        end
      end
      cyc++;
      @(negedge clk);
    end
    if (gcnt != eg) gbad++;
    chk("R2", "frame overhead cycles", mf, ef);
    chk("R3", "lines with wrong row overhead", rbad, 0);
    chk("R4", "lines with wrong group count", gbad, 0);
    chk("R4", "first column group", fg, efg);
    chk("R5", "line count", ml, el);
    chk("R5", "first row", fr, efr);
    chk("R5", "last row", lr, elr);
    chk("R5", "bad row steps", sbad, 0);
    chk("R10", "cycles to done", cyc, ef + el * (er + eg));
    chk("R9", "done seen", int'(frame_done), 1);
    chk("R9", "frame_valid during done", int'(frame_valid), 0);
    @(negedge clk);
    chk("R9", "done width", int'(frame_done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "frame_valid", int'(frame_valid), 0);
    chk("R1", "line_valid", int'(line_valid), 0);
    chk("R1", "frame_done", int'(frame_done), 0);
    chk("R1", "align_err", int'(align_err), 0);
    chk("R1", "row_addr", int'(row_addr), 0);
    chk("R1", "col_grp", int'(col_grp), 0);
    // R1 default settings: 315 / 13, full window
    run_frame(1'b1, 315, 13, BR, BC/12, 0, BR-1, 0, 1);

    for (int i = 0; i < 7; i++) begin
      load_vec(TBL[i]);
      chk("R6", "align flag after load", int'(align_err), int'(TBL[i].e_al));
      run_frame(1'b1, int'(TBL[i].e_f), int'(TBL[i].e_r), int'(TBL[i].e_l), int'(TBL[i].e_g),
                int'(TBL[i].e_fr), int'(TBL[i].e_lr), int'(TBL[i].e_fg),
                (TBL[i].sub != 0) ? 2 : 1);
    end

    // R7 write in the same cycle as the trigger: staged frame overhead is 1
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 16'd7; frame_trig = 1'b1;
    run_frame(1'b0, 1, 2, 1, 2, 5, 5, 0, 1);
    run_frame(1'b1, 7, 2, 1, 2, 5, 5, 0, 1);

    // R7 writes and a trigger while a frame runs
    wr(3'd5, 4);
    fork
      run_frame(1'b1, 7, 2, 4, 2, 5, 8, 0, 1);
      begin
        repeat (12) @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = 16'd5;
        @(negedge clk);
        cfg_we = 1'b0; frame_trig = 1'b1;
        @(negedge clk);
        frame_trig = 1'b0;
      end
    join
    begin
      int fv_seen;
      fv_seen = 0;
      for (int k = 0; k < 20; k++) begin
        if (frame_valid) fv_seen++;
        @(negedge clk);
      end
      chk("R7", "frame started by ignored trigger", fv_seen, 0);
    end
    run_frame(1'b1, 7, 5, 4, 2, 5, 8, 0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule